// File: doc/BRIEF.md
# Packed Pixel Unpacker with Colour Lookup

This block sits between a frame-buffer fetch engine and a display pipeline. It takes 32-bit words, each holding several packed pixels, and emits one 16-bit colour value per pixel. The pixels in a word are emitted least-significant field first. A depth code that travels with each word picks 1, 2, 4, 8 or 16 bits per pixel. At depths up to 8 bits, each field is an index into a colour table of up to 256 entries. At 16 bits the field is already a colour and is passed through without a lookup.

The colour table is a synchronous RAM. It is written through its own port, one 32-bit word per write, and each write fills two adjacent entries. The depth limits how much of the table is reached: 2 entries at 1 bit, 4 at 2 bits, 16 at 4 bits and all 256 at 8 bits. A grey flag that also travels with the word makes the block treat the low byte of the looked-up entry as a grey level and spread it over the three colour fields. Both the word input and the pixel output use valid/ready handshakes. The read latency of the table is hidden by a pipeline stage. The pass-through path goes through that same stage, so pixel order never changes.

Top module: `pix_unpack`

## Requirements
- R1: Pixel k of an accepted word comes from bits [k*b +: b], where b is the depth in bits. A word yields 32/b pixels, emitted in increasing k. Words are emitted in the order they were accepted.
- R2: The depth code bpp_mode selects the depth as follows: 0 gives 1 bit, 1 gives 2 bits, 2 gives 4 bits, 3 gives 8 bits and 4 gives 16 bits. Codes 5, 6 and 7 behave exactly like code 4.
- R3: A colour-table write with row address r stores wdata[15:0] as entry 2r and wdata[31:16] as entry 2r+1.
- R4: With the grey flag low and a depth of 8 bits or less, the output is the 16-bit table entry unchanged, read as red in bits 15:11, green in bits 10:5 and blue in bits 4:0.
- R5: With the grey flag high and a depth of 8 bits or less, let g be entry bits 7:0. The output is {g[7:3], g[7:2], g[7:3]}, and entry bits 15:8 have no effect.
- R6: At 16 bits per pixel, the word's bits 15:0 are emitted first and bits 31:16 second, both unchanged. The colour table and the grey flag have no effect.
- R7: While pix_valid is high and pix_ready is low, pix_valid stays high and pix_data holds its value. While pix_ready stays high, one pixel is emitted per cycle, with no gap between words.
- R8: word_ready is high when no accepted pixel is still outstanding. It is never high while more than two accepted pixels are still waiting to be emitted. A new word is therefore taken at the earliest in the cycle in which the last pixel of the current word enters the output stage.
- R9: bpp_mode and mono_en are sampled only together with an accepted word. Changing them at any other time has no effect on the pixels emitted.
- R10: Reset drives pix_valid low and word_ready high and throws away any partly unpacked word. The colour table contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bpp_mode | input | 3 | Depth code, sampled with each accepted word |
| mono_en | input | 1 | Grey flag, sampled with each accepted word |
| word_valid | input | 1 | Packed word offered |
| word_ready | output | 1 | Packed word can be taken |
| word_data | input | 32 | Packed pixel word |
| pal_we | input | 1 | Colour-table write strobe |
| pal_waddr | input | 7 | Colour-table row (entry pair) address |
| pal_wdata | input | 32 | Entry pair: even entry low, odd entry high |
| pix_valid | output | 1 | Pixel colour available |
| pix_ready | input | 1 | Pixel colour taken by the display pipeline |
| pix_data | output | 16 | Pixel colour value |

## Verification
A field pointer or shift amount that is off by one shows up as a wrong colour on the first pixel emitted after the fault. A depth latched at the wrong time shows up the same way: the next pixel after the fault has the wrong colour and the word ends up with the wrong pixel count. A pipeline stage that loses track of whether it holds a pixel would repeat a pixel, drop one or change the held value under backpressure, and this is visible within a single stall cycle. A pixel counter that releases word_ready too early or too late either lets more than two pixels pile up or stalls an idle block, and this is visible in the cycle where the handshake goes wrong.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

    localparam int unsigned PK_WORD_W = 32;
    localparam int unsigned PK_PIX_W  = 16;
    localparam int unsigned PK_IDX_W  = 8;
    localparam int unsigned PK_GREY_W = 8;
    localparam int unsigned PK_RED_W  = 5;
    localparam int unsigned PK_GRN_W  = 6;
    localparam int unsigned PK_BLU_W  = 5;

    typedef enum logic [2:0] {
        DEPTH_1  = 3'd0,
        DEPTH_2  = 3'd1,
        DEPTH_4  = 3'd2,
        DEPTH_8  = 3'd3,
        DEPTH_16 = 3'd4
    } depth_e;

    // field width in bits for a depth code; unknown codes act as 16
    function automatic int unsigned depth_bits(logic [2:0] code);
        case (code)
            DEPTH_1: depth_bits = 1;
            DEPTH_2: depth_bits = 2;
            DEPTH_4: depth_bits = 4;
            DEPTH_8: depth_bits = 8;
            default: depth_bits = 16;
        endcase
    endfunction

    function automatic logic depth_bypass(logic [2:0] code);
        depth_bypass = (depth_bits(code) == 16);
    endfunction

    function automatic int unsigned pix_per_word(logic [2:0] code);
        pix_per_word = PK_WORD_W / depth_bits(code);
    endfunction

endpackage

// File: rtl/pix_pal_ram.sv
module pix_pal_ram #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned ENT_W = 16
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [IDX_W-2:0]     waddr,
    input  logic [2*ENT_W-1:0]   wdata,
    input  logic                 re,
    input  logic [IDX_W-1:0]     raddr,
    output logic [ENT_W-1:0]     rdata
);
    localparam int unsigned ROW_W = IDX_W - 1;
    localparam int unsigned ROWS  = 1 << ROW_W;
    localparam int unsigned BANKS = 2;

    logic [ENT_W-1:0] bank_rd [BANKS];
    logic             sel_q;

    // bank 0 holds even entries (low half), bank 1 odd entries (high half)
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [ENT_W-1:0] mem [ROWS];
        logic [ENT_W-1:0] rd_q;
        always_ff @(posedge clk) begin
            if (we) begin
                mem[waddr] <= wdata[b*ENT_W +: ENT_W];
            end
            if (re) begin
                rd_q <= mem[raddr[IDX_W-1:1]];
            end
        end
        assign bank_rd[b] = rd_q;
    end

    always_ff @(posedge clk) begin
        if (re) begin
            sel_q <= raddr[0];
        end
    end

    assign rdata = bank_rd[sel_q];

endmodule

// File: rtl/pix_slicer.sv
module pix_slicer
    import pix_unpack_pkg::*;
#(
    parameter int unsigned WORD_W = PK_WORD_W,
    parameter int unsigned IDX_W  = PK_IDX_W,
    parameter int unsigned RAW_W  = PK_PIX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               word_valid,
    output logic               word_ready,
    input  logic [WORD_W-1:0]  word_data,
    input  logic [2:0]         bpp_mode,
    input  logic               mono_en,
    input  logic               take,
    output logic               issue_valid,
    output logic [IDX_W-1:0]   issue_idx,
    output logic [RAW_W-1:0]   issue_raw,
    output logic               issue_bypass,
    output logic               issue_mono
);
    localparam int unsigned CNT_W = $clog2(WORD_W);

    typedef struct packed {
        logic              busy;
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        mode;
        logic              mono;
    } slice_t;

    slice_t s_d, s_q;
    logic   consume;
    logic   is_last;
    logic [IDX_W-1:0] idx_mask;

    always_comb begin
        s_d      = s_q;
        consume  = take && s_q.busy;
        is_last  = (s_q.cnt == CNT_W'(pix_per_word(s_q.mode) - 1));
        word_ready = !s_q.busy || (consume && is_last);
        idx_mask = IDX_W'((32'd1 << depth_bits(s_q.mode)) - 32'd1);

        if (consume) begin
            s_d.shreg = s_q.shreg >> depth_bits(s_q.mode);
            s_d.cnt   = s_q.cnt + 1'b1;
            if (is_last) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
            end
        end

        // depth and grey flag are captured only here, with the word
        if (word_valid && word_ready) begin
            s_d.busy  = 1'b1;
            s_d.shreg = word_data;
            s_d.cnt   = '0;
            s_d.mode  = bpp_mode;
            s_d.mono  = mono_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign issue_valid  = s_q.busy;
    assign issue_idx    = s_q.shreg[IDX_W-1:0] & idx_mask;
    assign issue_raw    = s_q.shreg[RAW_W-1:0];
    assign issue_bypass = depth_bypass(s_q.mode);
    assign issue_mono   = s_q.mono;

endmodule

// File: rtl/pix_fmt.sv
module pix_fmt
    import pix_unpack_pkg::*;
#(
    parameter int unsigned PIX_W  = PK_PIX_W,
    parameter int unsigned GREY_W = PK_GREY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic              issue_bypass,
    input  logic              issue_mono,
    input  logic [PIX_W-1:0]  issue_raw,
    input  logic [PIX_W-1:0]  pal_rdata,
    output logic              take,
    output logic              rd_en,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic [PIX_W-1:0]  pix_data
);
    typedef struct packed {
        logic             vld;
        logic             bypass;
        logic             mono;
        logic [PIX_W-1:0] raw;
    } stage_t;

    stage_t o_d, o_q;
    logic [GREY_W-1:0] grey;
    logic [PIX_W-1:0]  grey_pix;

    always_comb begin
        o_d  = o_q;
        take = !o_q.vld || pix_ready;
        // table output register only moves when the stage moves
        rd_en = take && issue_valid && !issue_bypass;
        if (take) begin
            o_d.vld    = issue_valid;
            o_d.bypass = issue_bypass;
            o_d.mono   = issue_mono;
            o_d.raw    = issue_raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    always_comb begin
        grey     = pal_rdata[GREY_W-1:0];
        grey_pix = {grey[GREY_W-1 -: PK_RED_W],
                    grey[GREY_W-1 -: PK_GRN_W],
                    grey[GREY_W-1 -: PK_BLU_W]};
        if (o_q.bypass) begin
            pix_data = o_q.raw;
        end else if (o_q.mono) begin
            pix_data = grey_pix;
        end else begin
            pix_data = pal_rdata;
        end
    end

    assign pix_valid = o_q.vld;

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
    import pix_unpack_pkg::*;
#(
    parameter int unsigned WORD_W = PK_WORD_W,
    parameter int unsigned PIX_W  = PK_PIX_W,
    parameter int unsigned IDX_W  = PK_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bpp_mode,
    input  logic              mono_en,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word_data,
    input  logic              pal_we,
    input  logic [IDX_W-2:0]  pal_waddr,
    input  logic [WORD_W-1:0] pal_wdata,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic [PIX_W-1:0]  pix_data
);
    logic              take;
    logic              rd_en;
    logic              issue_valid;
    logic [IDX_W-1:0]  issue_idx;
    logic [PIX_W-1:0]  issue_raw;
    logic              issue_bypass;
    logic              issue_mono;
    logic [PIX_W-1:0]  pal_rdata;

    pix_slicer #(
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W),
        .RAW_W  (PIX_W)
    ) slicer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_valid   (word_valid),
        .word_ready   (word_ready),
        .word_data    (word_data),
        .bpp_mode     (bpp_mode),
        .mono_en      (mono_en),
        .take         (take),
        .issue_valid  (issue_valid),
        .issue_idx    (issue_idx),
        .issue_raw    (issue_raw),
        .issue_bypass (issue_bypass),
        .issue_mono   (issue_mono)
    );

    pix_pal_ram #(
        .IDX_W (IDX_W),
        .ENT_W (PIX_W)
    ) pal_i (
        .clk   (clk),
        .we    (pal_we),
        .waddr (pal_waddr),
        .wdata (pal_wdata),
        .re    (rd_en),
        .raddr (issue_idx),
        .rdata (pal_rdata)
    );

    pix_fmt #(
        .PIX_W  (PIX_W),
        .GREY_W (PK_GREY_W)
    ) fmt_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_valid  (issue_valid),
        .issue_bypass (issue_bypass),
        .issue_mono   (issue_mono),
        .issue_raw    (issue_raw),
        .pal_rdata    (pal_rdata),
        .take         (take),
        .rd_en        (rd_en),
        .pix_valid    (pix_valid),
        .pix_ready    (pix_ready),
        .pix_data     (pix_data)
    );

endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk
    import pix_unpack_pkg::*;
#(
    parameter int unsigned PIX_W = PK_PIX_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       bpp_mode,
    input logic             word_valid,
    input logic             word_ready,
    input logic             pix_valid,
    input logic             pix_ready,
    input logic [PIX_W-1:0] pix_data
);
    // pixels accepted with words but not yet handed out
    logic [7:0] pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= pend
                  + ((word_valid && word_ready) ? 8'(pix_per_word(bpp_mode)) : 8'd0)
                  - ((pix_valid && pix_ready) ? 8'd1 : 8'd0);
        end
    end

    // R10
    always @(posedge clk) begin
        if (!rst_n) begin
            rst_out_chk: assert (!pix_valid && word_ready)
                else $error("outputs not idle in reset");
        end
    end

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_ready |=> pix_valid && $stable(pix_data));

    // R1
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> pend != 8'd0);

    // R8
    word_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && word_ready |-> pend <= 8'd2);

    // R8
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend == 8'd0 |-> word_ready);

endmodule

bind pix_unpack pix_unpack_chk #(.PIX_W(PIX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bpp_mode   (bpp_mode),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .pix_valid  (pix_valid),
    .pix_ready  (pix_ready),
    .pix_data   (pix_data)
);

// File: tb/pix_unpack_tb_top.sv
module pix_unpack_tb_top;
    import pix_unpack_pkg::*;

    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bpp_mode = '0;
    logic        mono_en = 1'b0;
    logic        word_valid = 1'b0;
    logic        word_ready;
    logic [31:0] word_data = '0;
    logic        pal_we = 1'b0;
    logic [6:0]  pal_waddr = '0;
    logic [31:0] pal_wdata = '0;
    logic        pix_valid;
    logic        pix_ready = 1'b0;
    logic [15:0] pix_data;

    always #5 clk = ~clk;

    pix_unpack dut_i (
        .clk(clk), .rst_n(rst_n), .bpp_mode(bpp_mode), .mono_en(mono_en),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
        .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data)
    );

    typedef struct {
        logic [15:0] v;
        string       tag;
    } exp_t;

    logic [15:0] pal_m [256];
    exp_t        expq [$];
    int          checks = 0;
    int          fails = 0;
    int          cycles = 0;
    bit          timeout = 0;
    bit          hold_pend = 0;
    logic [15:0] held = '0;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // R1 R2 R4 R5 R6: expected colour of pixel k
    function automatic exp_t exp_pix(logic [31:0] w, logic [2:0] md, logic mn, int k);
        exp_t e;
        int b;
        logic [31:0] f;
        logic [15:0] ent;
        logic [7:0]  g;
        b = (md == 3'd0) ? 1 : (md == 3'd1) ? 2 : (md == 3'd2) ? 4 : (md == 3'd3) ? 8 : 16;
        f = (w >> (k * b)) & ((32'd1 << b) - 32'd1);
        if (b == 16) begin
            e.v   = f[15:0];
            e.tag = (md > 3'd4) ? "R1/R2" : "R1/R6";
        end else begin
            ent = pal_m[f[7:0]];
            g   = ent[7:0];
            e.v   = mn ? {g[7:3], g[7:2], g[7:3]} : ent;
            e.tag = mn ? "R1/R5" : "R1/R4";
        end
        return e;
    endfunction

    task automatic step(logic wv, logic [31:0] wd, logic [2:0] md, logic mn,
                        int rdy_pct, output bit accepted);
        int n;
        @(negedge clk);
        word_valid = wv;
        word_data  = wd;
        // R9: outside an offered word the mode inputs wander
        bpp_mode   = wv ? md : 3'($urandom_range(0, 7));
        mono_en    = wv ? mn : 1'($urandom_range(0, 1));
        pix_ready  = ($urandom_range(0, 99) < rdy_pct);
        #1;
        // R8
        if (expq.size() == 0)
            check(word_ready === 1'b1, "R8 idle ready", word_ready, 1);
        if (word_ready && expq.size() > 2)
            check(0, "R8 early ready", expq.size(), 2);
        // R7
        if (hold_pend)
            check(pix_valid && pix_data === held, "R7 hold", pix_data, held);
        hold_pend = pix_valid && !pix_ready;
        held = pix_data;
        if (pix_valid && pix_ready) begin
            if (expq.size() == 0) begin
                check(0, "R1 extra pixel", pix_data, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(pix_data === e.v, e.tag, pix_data, e.v);
            end
        end
        accepted = wv && word_ready;
        if (accepted) begin
            n = (md == 3'd0) ? 32 : (md == 3'd1) ? 16 : (md == 3'd2) ? 8 : (md == 3'd3) ? 4 : 2;
            for (int k = 0; k < n; k++) expq.push_back(exp_pix(wd, md, mn, k));
        end
        cycles++;
        if (cycles > LIMIT) timeout = 1;
    endtask

    task automatic send_word(logic [31:0] w, logic [2:0] md, logic mn, int rdy);
        bit acc;
        acc = 0;
        while (!acc && !timeout) step(1'b1, w, md, mn, rdy, acc);
    endtask

    task automatic idle(int n, int rdy);
        bit acc;
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0, rdy, acc);
    endtask

    task automatic drain();
        bit acc;
        int guard;
        guard = 0;
        while ((expq.size() != 0 || pix_valid) && guard < 400 && !timeout) begin
            step(1'b0, '0, '0, 1'b0, 100, acc);
            guard++;
        end
        check(expq.size() == 0, "R1 drain", expq.size(), 0);
    endtask

    // R3: each write fills entries 2r and 2r+1
    task automatic load_pal();
        for (int r = 0; r < 128; r++) begin
            @(negedge clk);
            pal_we    = 1'b1;
            pal_waddr = 7'(r);
            pal_wdata = $urandom;
            pal_m[2*r]   = pal_wdata[15:0];
            pal_m[2*r+1] = pal_wdata[31:16];
        end
        @(negedge clk);
        pal_we = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        #1;
        // R10 reset state
        check(pix_valid === 1'b0, "R10 reset valid", pix_valid, 0);
        check(word_ready === 1'b1, "R10 reset ready", word_ready, 1);
        @(negedge clk);
        rst_n = 1'b1;
        load_pal();

        // R6 directed: low half first
        send_word(32'hABCD_1234, 3'd4, 1'b1, 100);
        // R2 directed: code 7 acts as 16 bits
        send_word(32'h5A5A_C3C3, 3'd7, 1'b0, 100);
        // R1 directed: 1 bit, bit 0 first
        send_word(32'h8000_0001, 3'd0, 1'b0, 100);
        // R3 directed: 8-bit indices hitting both halves of one row
        send_word(32'h0B0A_0504, 3'd3, 1'b0, 100);
        // R5 directed: grey expansion
        send_word(32'h0000_00FF, 3'd3, 1'b1, 100);
        drain();

        // R7 backpressure, R9 wandering mode, random mix
        for (int i = 0; i < 300 && !timeout; i++) begin
            send_word($urandom, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                      (i < 150) ? 100 : 60);
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3), 70);
        end
        drain();

        // R10 reset mid-word discards the rest; table survives
        send_word($urandom, 3'd0, 1'b0, 100);
        idle(5, 100);
        @(negedge clk);
        rst_n = 1'b0;
        word_valid = 1'b0;
        #1;
        check(pix_valid === 1'b0, "R10 mid reset valid", pix_valid, 0);
        check(word_ready === 1'b1, "R10 mid reset ready", word_ready, 1);
        expq.delete();
        hold_pend = 0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 20 && !timeout; i++)
            send_word($urandom, 3'($urandom_range(0, 4)), 1'($urandom_range(0, 1)), 80);
        drain();

        if (timeout) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, LIMIT);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule